// File: doc/BRIEF.md
# Programmable Asynchronous Serial Channel

One full-duplex asynchronous serial channel that a host programs through four byte-wide registers picked by a 2-bit index. Index 0 moves characters (write loads the transmit holding register, read takes the received character), index 1 reads a status byte, index 2 reaches two mode bytes through an internal pointer, and index 3 holds the command byte. The block's clock is the 5.0688 MHz reference. A sixteen-entry rate table divides it down to a tick at sixteen times the chosen bit rate, and both the transmitter and the receiver count those ticks.

The mode bytes set the character length (5 to 8 bits), parity, the stop length and the bit rate. The command byte enables the transmitter and the receiver, drives the two modem outputs, forces a break, clears the sticky error flags and picks one of four line modes: normal, automatic echo, local loopback or remote loopback. Bring-up writes the first mode byte, then the second, then the command byte. For example, mode bytes 0xEE and 0x7E followed by command 0x27 give 8 data bits, no parity, 2 stop bits at 9600 baud, with DTR and RTS active.

Top module: `sio_channel`

## Requirements
- R1: After reset, TxD, RTS_n and DTR_n are high, tx_ready and rx_ready are low, and the status byte (index 1) reads 0x01 while DSR_n and DCD_n are high.
- R2: Both mode bytes sit at index 2. A pointer sends the first access (read or write) to mode byte 1 and the next access to mode byte 2, then wraps back. Any read or write of index 3 returns the pointer to mode byte 1.
- R3: Mode byte 2 bits 3:0 select the rate. Each rate's divisor is 5.0688 MHz / (16 x rate), rounded to the nearest integer, and one bit lasts 16 divisor periods. Code 1110 is 9600 baud (528 clocks per bit) and code 1111 is 19200 baud (272 clocks per bit).
- R4: A transmitted frame is a low start bit, then the data LSB first, then the parity bit if mode byte 1 bit 4 is set (bit 5 = 1 even, 0 odd), then high stop time of 1, 1.5 or 2 bits for mode bits 7:6 = 01, 10, 11. Mode bits 3:2 give a length of 5 + code bits. A character waiting in the holding register starts right after the previous stop time ends.
- R5: A received character is right-justified in the data byte with its upper bits zero. Status bit 1 and rx_ready go high when it arrives, and reading index 0 clears both.
- R6: A received parity mismatch sets status bit 3, and a low stop bit sets status bit 5. Both stay set until a command write with bit 4 = 1.
- R7: If a character completes while the receive holding register is still full, status bit 4 (overrun) sets. The held character is kept and the new one is discarded.
- R8: Transmission starts only while command bit 0 is 1 and CTS_n is low (CTS_n is ignored in local loopback). Status bit 0 shows that the holding register is empty. tx_ready is that flag ANDed with command bit 0.
- R9: Command bit 3 = 1 holds TxD low in normal mode.
- R10: Command bits 7:6 select the line mode: 00 normal; 01 echo, where TxD follows RxD and the receiver still works; 10 local loopback, where the transmitter feeds the receiver and TxD stays high; 11 remote loopback, where TxD follows RxD and nothing is received.
- R11: Command bit 1 = 1 drives DTR_n low, and bit 5 = 1 drives RTS_n low. Status bit 7 is 1 while DSR_n is low, and bit 6 is 1 while DCD_n is low. Status bit 2 is the OR of "transmitter enabled and fully empty" and a change flag. The change flag is set by any change on DSR_n or DCD_n and cleared by a status read. A set in the same cycle as the clear wins.
- R12: With command bit 2 = 0 the receiver ignores the line, and no character arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5.0688 MHz reference and system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 2 | Register index: 0 data, 1 status, 2 mode, 3 command |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access (side effects at the edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current index |
| tx_ready | output | 1 | Holding register free and transmitter enabled |
| rx_ready | output | 1 | Received character waiting |
| txd | output | 1 | Serial transmit line, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rxd | input | 1 | Serial receive line, idle high |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| dcd_n | input | 1 | Carrier detect, active low |

## Verification
Two things can land on the change flag in the same cycle: a status read that clears it, and a new edge on DSR_n that sets it. The bench toggles DSR_n at six different offsets before a status read and then does a second read. Each offset therefore sweeps the synchronised edge across the cycle of the first read. For every offset the change must show up in exactly one of the two reads. A lost edge, where the clear beats the set, or a flag that never clears, both fail.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

   localparam int unsigned N_RATES = 16;

   typedef enum logic [1:0] {
      LM_NORMAL = 2'b00,
      LM_ECHO   = 2'b01,
      LM_LOCAL  = 2'b10,
      LM_REMOTE = 2'b11
   } line_mode_e;

   typedef struct packed {
      logic [1:0] stop;
      logic       par_even;
      logic       par_en;
      logic [1:0] len;
      logic [1:0] factor;
   } mode1_t;

   // bit rate times ten, so that 134.5 stays an integer
   function automatic longint unsigned rate_x10(input int unsigned code);
      case (code)
         0:  return 500;
         1:  return 750;
         2:  return 1100;
         3:  return 1345;
         4:  return 1500;
         5:  return 3000;
         6:  return 6000;
         7:  return 12000;
         8:  return 18000;
         9:  return 20000;
         10: return 24000;
         11: return 36000;
         12: return 48000;
         13: return 72000;
         14: return 96000;
         default: return 192000;
      endcase
   endfunction

   // rounded divisor for a 16x tick
   function automatic longint unsigned rate_div(input longint unsigned clk_hz,
                                                input int unsigned code);
      longint unsigned den;
      den = 16 * rate_x10(code);
      return (clk_hz * 10 + den / 2) / den;
   endfunction

   function automatic logic [7:0] len_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

endpackage

// File: rtl/sio_sync.sv
`timescale 1ns/1ps
module sio_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad
      $error("sio_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_baud.sv
`timescale 1ns/1ps
module sio_baud
   import sio_pkg::*;
#(
   parameter longint unsigned CLK_HZ = 5068800,
   parameter int unsigned     DIV_W  = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] sel,
   output logic       tick
);
   logic [DIV_W-1:0] div_tab [N_RATES];
   logic [DIV_W-1:0] cnt;

   for (genvar g = 0; g < N_RATES; g++) begin : g_tab
      localparam longint unsigned D = rate_div(CLK_HZ, g);
      if (D < 2 || D >= (64'd1 << DIV_W)) begin : g_bad
         $error("sio_baud: divisor out of range for rate code");
      end
      assign div_tab[g] = DIV_W'(D);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (cnt >= div_tab[sel] - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R3: every divisor is at least two, so ticks never touch
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  mode1_t     mode,
   input  logic       go_ok,
   input  logic       thr_wr,
   input  logic [7:0] thr_din,
   output logic       thr_empty,
   output logic       idle,
   output logic       ser
);
   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

   tx_st_e     state;
   logic [7:0] thr_q, sh;
   logic [4:0] sub;
   logic [2:0] bitn;
   logic       par_q;
   logic [4:0] stop_last;
   logic [2:0] last_bit;
   logic [7:0] dm;
   logic       stop_end, load;

   always_comb begin
      case (mode.stop)
         2'b10:   stop_last = 5'd23;
         2'b11:   stop_last = 5'd31;
         default: stop_last = 5'd15;
      endcase
   end

   assign last_bit = 3'(mode.len) + 3'd4;
   assign dm       = thr_q & len_mask(mode.len);
   assign stop_end = (state == T_STOP) && (sub == stop_last);
   assign load     = tick && (state == T_IDLE || stop_end) && !thr_empty && go_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= T_IDLE;
         thr_q     <= '0;
         thr_empty <= 1'b1;
         sh        <= '0;
         sub       <= '0;
         bitn      <= '0;
         par_q     <= 1'b0;
      end else begin
         if (load) begin
            state     <= T_START;
            sub       <= '0;
            sh        <= dm;
            par_q     <= (^dm) ^ ~mode.par_even;
            thr_empty <= 1'b1;
         end else if (tick) begin
            case (state)
               T_START: if (sub == 5'd15) begin
                           state <= T_DATA; sub <= '0; bitn <= '0;
                        end else sub <= sub + 1'b1;
               T_DATA:  if (sub == 5'd15) begin
                           sub <= '0;
                           sh  <= sh >> 1;
                           if (bitn == last_bit) state <= mode.par_en ? T_PAR : T_STOP;
                           else bitn <= bitn + 1'b1;
                        end else sub <= sub + 1'b1;
               T_PAR:   if (sub == 5'd15) begin
                           state <= T_STOP; sub <= '0;
                        end else sub <= sub + 1'b1;
               T_STOP:  if (stop_end) state <= T_IDLE;
                        else sub <= sub + 1'b1;
               default: ;
            endcase
         end
         if (thr_wr) begin
            thr_q     <= thr_din;
            thr_empty <= 1'b0;
         end
      end
   end

   always_comb begin
      case (state)
         T_START: ser = 1'b0;
         T_DATA:  ser = sh[0];
         T_PAR:   ser = par_q;
         default: ser = 1'b1;
      endcase
   end

   assign idle = (state == T_IDLE);

   // R8: a frame only begins when the transmitter was allowed to go
   a_r8_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
      (state == T_START && $past(state) != T_START) |-> $past(go_ok));
   // R4: the data bit counter never passes the programmed length
   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == T_DATA) |-> (bitn <= last_bit));
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic       en,
   input  mode1_t     mode,
   input  logic       take,
   input  logic       err_clr,
   output logic [7:0] hold,
   output logic       full,
   output logic       pe,
   output logic       oe,
   output logic       fe
);
   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

   rx_st_e     state;
   logic [7:0] sh;
   logic [3:0] sub;
   logic [2:0] bitn;
   logic       pbit, armed;
   logic [2:0] last_bit;
   logic       done;

   assign last_bit = 3'(mode.len) + 3'd4;
   assign done     = tick && en && (state == R_STOP) && (sub == 4'd15);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= R_IDLE;
         sh    <= '0;
         sub   <= '0;
         bitn  <= '0;
         pbit  <= 1'b0;
         armed <= 1'b0;
         hold  <= '0;
         full  <= 1'b0;
         pe    <= 1'b0;
         oe    <= 1'b0;
         fe    <= 1'b0;
      end else begin
         if (take)    full <= 1'b0;
         if (err_clr) begin pe <= 1'b0; oe <= 1'b0; fe <= 1'b0; end
         if (!en) begin
            state <= R_IDLE;
         end else if (tick) begin
            case (state)
               R_IDLE:  begin
                           if (line) armed <= 1'b1;
                           else if (armed) begin
                              state <= R_START; sub <= '0; sh <= '0;
                           end
                        end
               R_START: if (sub == 4'd7) begin
                           sub <= '0; bitn <= '0;
                           state <= line ? R_IDLE : R_DATA;
                        end else sub <= sub + 1'b1;
               R_DATA:  if (sub == 4'd15) begin
                           sub <= '0;
                           sh[bitn] <= line;
                           if (bitn == last_bit) state <= mode.par_en ? R_PAR : R_STOP;
                           else bitn <= bitn + 1'b1;
                        end else sub <= sub + 1'b1;
               R_PAR:   if (sub == 4'd15) begin
                           sub <= '0; pbit <= line; state <= R_STOP;
                        end else sub <= sub + 1'b1;
               R_STOP:  if (sub == 4'd15) begin
                           state <= R_IDLE;
                           armed <= line;
                           if (full && !take) begin
                              oe <= 1'b1;
                           end else begin
                              hold <= sh;
                              full <= 1'b1;
                              if (!line) fe <= 1'b1;
                              if (mode.par_en && (pbit != ((^sh) ^ ~mode.par_even))) pe <= 1'b1;
                           end
                        end else sub <= sub + 1'b1;
               default: state <= R_IDLE;
            endcase
         end
      end
   end

   // R7: an overrun keeps the held character
   a_r7_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full && !take) |=> ($stable(hold) && oe));
   // R5: the ready flag only rises at the end of a frame
   a_r5_full_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(done));
endmodule

// File: rtl/sio_channel.sv
`timescale 1ns/1ps
module sio_channel
   import sio_pkg::*;
#(
   parameter longint unsigned CLK_HZ      = 5068800,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_idx,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       tx_ready,
   output logic       rx_ready,
   output logic       txd,
   output logic       rts_n,
   output logic       dtr_n,
   input  logic       rxd,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       dcd_n
);
   localparam int unsigned DIV_W = $clog2(rate_div(CLK_HZ, 0) + 1);

   mode1_t     mode1_q;
   logic [7:0] mode2_q, cmd_q;
   logic       ptr_q, dschg_q, txd_q;
   logic [3:0] pins_s;
   logic       rxd_s, cts_s, dsr_s, dcd_s, dsr_d, dcd_d;
   logic       tick, thr_empty, tx_idle, tx_ser;
   logic [7:0] hold;
   logic       full, pe, oe, fe;
   line_mode_e lm;
   logic       go_ok, rx_en, rx_line, txemt;
   logic       acc_cmd, acc_mode, stat_rd, data_rd;
   logic [7:0] status;

   sio_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({rxd, cts_n, dsr_n, dcd_n}), .q(pins_s));
   assign {rxd_s, cts_s, dsr_s, dcd_s} = pins_s;

   sio_baud #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .sel(mode2_q[3:0]), .tick(tick));

   assign lm      = line_mode_e'(cmd_q[7:6]);
   assign go_ok   = cmd_q[0] && (!cts_s || lm == LM_LOCAL);
   assign rx_en   = cmd_q[2] && (lm != LM_REMOTE);
   assign rx_line = (lm == LM_LOCAL) ? tx_ser : rxd_s;

   assign acc_cmd  = (wr_en || rd_en) && reg_idx == 2'd3;
   assign acc_mode = (wr_en || rd_en) && reg_idx == 2'd2;
   assign stat_rd  = rd_en && reg_idx == 2'd1;
   assign data_rd  = rd_en && reg_idx == 2'd0;

   sio_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode1_q), .go_ok(go_ok),
      .thr_wr(wr_en && reg_idx == 2'd0), .thr_din(wdata),
      .thr_empty(thr_empty), .idle(tx_idle), .ser(tx_ser));

   sio_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_line), .en(rx_en),
      .mode(mode1_q), .take(data_rd), .err_clr(wr_en && reg_idx == 2'd3 && wdata[4]),
      .hold(hold), .full(full), .pe(pe), .oe(oe), .fe(fe));

   assign txemt  = cmd_q[0] && thr_empty && tx_idle;
   assign status = {~dsr_s, ~dcd_s, fe, oe, pe, txemt | dschg_q, full, thr_empty};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode1_q <= '0;
         mode2_q <= '0;
         cmd_q   <= '0;
         ptr_q   <= 1'b0;
         dschg_q <= 1'b0;
         dsr_d   <= 1'b1;
         dcd_d   <= 1'b1;
         txd_q   <= 1'b1;
      end else begin
         if (wr_en && reg_idx == 2'd2) begin
            if (ptr_q) mode2_q <= wdata;
            else       mode1_q <= mode1_t'(wdata);
         end
         if (wr_en && reg_idx == 2'd3) cmd_q <= wdata;
         if (acc_cmd)       ptr_q <= 1'b0;
         else if (acc_mode) ptr_q <= ~ptr_q;
         dsr_d <= dsr_s;
         dcd_d <= dcd_s;
         if (dsr_s != dsr_d || dcd_s != dcd_d) dschg_q <= 1'b1;
         else if (stat_rd)                     dschg_q <= 1'b0;
         case (lm)
            LM_NORMAL: txd_q <= cmd_q[3] ? 1'b0 : tx_ser;
            LM_LOCAL:  txd_q <= 1'b1;
            default:   txd_q <= rxd_s;
         endcase
      end
   end

   always_comb begin
      case (reg_idx)
         2'd0:    rdata = hold;
         2'd1:    rdata = status;
         2'd2:    rdata = ptr_q ? mode2_q : mode1_q;
         default: rdata = cmd_q;
      endcase
   end

   assign txd      = txd_q;
   assign rts_n    = ~cmd_q[5];
   assign dtr_n    = ~cmd_q[1];
   assign tx_ready = thr_empty && cmd_q[0];
   assign rx_ready = full;

   // R2: a command access always homes the mode pointer
   a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cmd |=> !ptr_q);
   // R11: a status read with no fresh edge leaves the change flag clear
   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && dsr_s == dsr_d && dcd_s == dcd_d) |=> !dschg_q);
endmodule

// File: tb/sio_channel_test.sv
`timescale 1ns/1ps
module sio_channel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_idx = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tx_ready, rx_ready, txd, rts_n, dtr_n;
   logic       rxd = 1'b1, cts_n = 1'b0, dsr_n = 1'b1, dcd_n = 1'b1;

   int checks = 0, errors = 0;
   bit lock = 0, mon_en = 0, finished = 0;

   typedef struct { logic [7:0] d; logic [2:0] e; } item_t;
   item_t exp_q[$];

   sio_channel uut (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .tx_ready(tx_ready), .rx_ready(rx_ready),
      .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n), .rxd(rxd), .cts_n(cts_n),
      .dsr_n(dsr_n), .dcd_n(dcd_n));

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic grab();
      while (lock) @(negedge clk);
      lock = 1;
   endtask

   task automatic wr(input logic [1:0] idx, input logic [7:0] d);
      grab();
      @(negedge clk); reg_idx = idx; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      lock = 0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [7:0] d);
      grab();
      @(negedge clk); reg_idx = idx; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
      lock = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      int t = 0;
      while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
      chk(exp_q.size() == 0, "R5 expected characters delivered", exp_q.size(), 0);
   endtask

   // drive one frame onto rxd
   task automatic line_char(input logic [7:0] d, input int nb, input bit pen,
                            input bit peven, input bit bad_par, input bit bad_stop,
                            input int per);
      logic p;
      p = ^(d & (8'hFF >> (8 - nb)));
      p = peven ? p : ~p;
      rxd = 1'b0; idle(per);
      for (int i = 0; i < nb; i++) begin rxd = d[i]; idle(per); end
      if (pen) begin rxd = p ^ bad_par; idle(per); end
      rxd = ~bad_stop; idle(per);
      rxd = 1'b1; idle(2 * per);
   endtask

   task automatic cap_after_fall(input int nb, input int per, output logic [7:0] d);
      d = '0;
      idle(per / 2);
      chk(txd == 1'b0, "R4 start bit low", txd, 0);
      for (int i = 0; i < nb; i++) begin idle(per); d[i] = txd; end
   endtask

   task automatic cap_frame(input int nb, input int per, output logic [7:0] d);
      @(negedge txd);
      cap_after_fall(nb, per, d);
   endtask

   task automatic wait_txr();
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic cfg(input logic [7:0] m1, input logic [7:0] m2, input logic [7:0] c);
      wr(2'd2, m1); wr(2'd2, m2); wr(2'd3, c);
   endtask

   task automatic loop_send(input logic [7:0] d, input logic [7:0] expd);
      item_t it;
      wait_txr();
      it.d = expd; it.e = 3'b000;
      exp_q.push_back(it);
      wr(2'd0, d);
      idle(150);
      chk(txd == 1'b1, "R10 local loopback keeps TxD high", txd, 1);
   endtask

   task automatic expect_rx(input logic [7:0] d, input logic [2:0] e);
      item_t it;
      it.d = d; it.e = e;
      exp_q.push_back(it);
   endtask

   // scoreboard monitor: status then data for every arriving character
   initial begin
      logic [7:0] st, d;
      item_t it;
      forever begin
         @(negedge clk);
         if (mon_en && rx_ready) begin
            rd(2'd1, st);
            rd(2'd0, d);
            if (exp_q.size() == 0) begin
               chk(0, "R5 R12 unexpected received character", d, 0);
            end else begin
               it = exp_q.pop_front();
               chk(d == it.d, "R5 received data", d, it.d);
               chk({st[5], st[4], st[3]} == it.e, "R6 error flags of character", st[5:3], it.e);
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hang expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, a, b, d1, d2;
      int gap;
      bit low_seen;
      idle(5);
      rst_n = 1'b1;
      idle(4);
      // R1 reset state
      chk(txd == 1 && rts_n == 1 && dtr_n == 1, "R1 output pins idle", {txd, rts_n, dtr_n}, 3'b111);
      chk(tx_ready == 0 && rx_ready == 0, "R1 ready flags low", {tx_ready, rx_ready}, 0);
      rd(2'd1, v);
      chk(v == 8'h01, "R1 reset status", v, 8'h01);

      // R2 mode pointer
      wr(2'd2, 8'hEE); wr(2'd2, 8'h7E);
      rd(2'd2, v); chk(v == 8'hEE, "R2 first mode read", v, 8'hEE);
      rd(2'd2, v); chk(v == 8'h7E, "R2 second mode read", v, 8'h7E);
      rd(2'd2, v); chk(v == 8'hEE, "R2 pointer wraps", v, 8'hEE);
      rd(2'd3, v); chk(v == 8'h00, "R2 command reads zero", v, 0);
      rd(2'd2, v); chk(v == 8'hEE, "R2 command read homes pointer", v, 8'hEE);
      wr(2'd3, 8'h27);
      rd(2'd3, v); chk(v == 8'h27, "R2 command readback", v, 8'h27);
      chk(rts_n == 0 && dtr_n == 0, "R11 RTS and DTR active", {rts_n, dtr_n}, 0);
      chk(tx_ready == 1, "R8 tx_ready with transmitter on", tx_ready, 1);
      mon_en = 1;

      // R3 R4: 9600 baud, 8N2, back-to-back characters
      fork
         begin
            cap_frame(8, 528, d1);
            gap = 0;
            while (txd) begin @(negedge clk); gap++; end
            cap_after_fall(8, 528, d2);
         end
         begin
            wr(2'd0, 8'hA5);
            idle(2); wait_txr();
            wr(2'd0, 8'h3C);
         end
      join
      chk(d1 == 8'hA5, "R3 R4 first frame at 9600", d1, 8'hA5);
      chk(d2 == 8'h3C, "R4 second frame", d2, 8'h3C);
      chk(gap >= 1316 && gap <= 1324, "R3 R4 two stop bits then immediate start", gap, 1320);
      idle(1200);

      // R10 local loopback at 19200, several formats
      cfg(8'h4E, 8'h3F, 8'h85);
      loop_send(8'h00, 8'h00);
      loop_send(8'hFF, 8'hFF);
      loop_send(8'h5A, 8'h5A);
      drain(); idle(600);
      cfg(8'h7A, 8'h3F, 8'h85);
      loop_send(8'hC1, 8'h41);
      drain(); idle(600);
      cfg(8'h92, 8'h3F, 8'h85);
      loop_send(8'h3F, 8'h1F);
      loop_send(8'hE6, 8'h06);
      drain(); idle(600);
      cfg(8'hF6, 8'h3F, 8'h85);
      loop_send(8'h2B, 8'h2B);
      drain(); idle(600);

      // R6 parity and framing errors, 8 bits odd parity, receiver only
      cfg(8'h5E, 8'h3F, 8'h26);
      expect_rx(8'h96, 3'b000);
      line_char(8'h96, 8, 1, 0, 0, 0, 272);
      drain();
      expect_rx(8'h3A, 3'b001);
      line_char(8'h3A, 8, 1, 0, 1, 0, 272);
      drain();
      wr(2'd3, 8'h36);
      rd(2'd1, v); chk(v[5:3] == 3'b000, "R6 error reset clears flags", v[5:3], 0);
      expect_rx(8'h81, 3'b100);
      line_char(8'h81, 8, 1, 0, 0, 1, 272);
      drain();
      rd(2'd1, v); chk(v[5] == 1'b1, "R6 framing flag sticky", v[5], 1);
      wr(2'd3, 8'h36);
      rd(2'd1, v); chk(v[5:3] == 3'b000, "R6 framing flag cleared", v[5:3], 0);

      // R7 overrun
      mon_en = 0;
      line_char(8'h11, 8, 1, 0, 0, 0, 272);
      line_char(8'h22, 8, 1, 0, 0, 0, 272);
      rd(2'd1, v); chk(v[4] == 1 && v[1] == 1, "R7 overrun and ready set", v, 8'h12);
      rd(2'd0, v); chk(v == 8'h11, "R7 older character kept", v, 8'h11);
      rd(2'd1, v); chk(v[1] == 0, "R5 data read clears ready", v[1], 0);
      wr(2'd3, 8'h36);
      mon_en = 1;

      // R12 receiver off
      wr(2'd3, 8'h22);
      line_char(8'h55, 8, 1, 0, 0, 0, 272);
      idle(20);
      rd(2'd1, v); chk(rx_ready == 0 && v[1] == 0, "R12 disabled receiver ignores line", v[1], 0);

      // R8 CTS gating
      cfg(8'h4E, 8'h3F, 8'h27);
      cts_n = 1'b1;
      idle(10);
      wr(2'd0, 8'h77);
      low_seen = 0;
      for (int i = 0; i < 2000; i++) begin @(negedge clk); if (!txd) low_seen = 1; end
      chk(!low_seen, "R8 no frame while CTS_n high", low_seen, 0);
      rd(2'd1, v); chk(v[0] == 0 && tx_ready == 0, "R8 holding register still full", v[0], 0);
      fork
         cap_frame(8, 272, d1);
         begin idle(3); cts_n = 1'b0; end
      join
      chk(d1 == 8'h77, "R8 frame after CTS_n low", d1, 8'h77);
      idle(800);

      // R9 break
      wr(2'd3, 8'h2F); idle(5);
      chk(txd == 0, "R9 break holds TxD low", txd, 0);
      wr(2'd3, 8'h27); idle(5);
      chk(txd == 1, "R9 break released", txd, 1);

      // R10 echo and remote loopback
      wr(2'd3, 8'h45);
      expect_rx(8'h6C, 3'b000);
      fork
         line_char(8'h6C, 8, 0, 0, 0, 0, 272);
         cap_frame(8, 272, d1);
      join
      chk(d1 == 8'h6C, "R10 echo relays RxD", d1, 8'h6C);
      drain();
      wr(2'd3, 8'hC5);
      fork
         line_char(8'h3D, 8, 0, 0, 0, 0, 272);
         cap_frame(8, 272, d1);
      join
      chk(d1 == 8'h3D, "R10 remote loopback relays RxD", d1, 8'h3D);
      idle(20);
      chk(rx_ready == 0, "R10 remote loopback receives nothing", rx_ready, 0);

      // R11 modem inputs and change flag
      wr(2'd3, 8'h04);
      idle(5); rd(2'd1, v);
      dsr_n = 1'b0; idle(6);
      rd(2'd1, v); chk(v[7] == 1 && v[2] == 1, "R11 DSR low and change seen", v, 8'h84);
      rd(2'd1, v); chk(v[2] == 0 && v[7] == 1, "R11 status read clears change", v, 8'h80);
      dcd_n = 1'b0; idle(6);
      rd(2'd1, v); chk(v[6] == 1 && v[2] == 1, "R11 DCD low and change seen", v, 8'hC4);
      dcd_n = 1'b1; dsr_n = 1'b1; idle(6);
      rd(2'd1, v);

      // R11 same-cycle set and clear sweep
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         fork
            begin idle(k); dsr_n = ~dsr_n; end
            begin idle(3); rd(2'd1, a); end
         join
         idle(8);
         rd(2'd1, b);
         chk((a[2] ^ b[2]) == 1'b1, "R11 change reported exactly once", {a[2], b[2]}, 1);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule